// File: doc/BRIEF.md
# Interrupt status register bank

This block keeps the interrupt state of a command-processing peripheral. It has five sources: a command was accepted, a command finished with success, a command failed, a command was rejected, and a read overflowed. Each source has a sticky status bit. A one-cycle pulse on the matching hardware event input sets the bit. Software can also force bits high through a write-one-to-set register and drop them through a write-one-to-clear register. A per-source enable mask selects which status bits drive the single registered interrupt line.

A separate command status register holds two flags: command succeeded and command failed. The hardware success and fail events set these flags. Forcing the success or fail interrupt from software sets them as well. Clearing interrupt status leaves the flags alone. Software clears the flags in their own register. Reads are combinational from the address, and status reads always show the raw bits, whatever the enable mask holds.

Top module: `irq_status_bank`

## Requirements
- R1: After reset, the status bits, the enable mask and both command flags are 0, and irq_out is 0.
- R2: A write to byte offset 0x8 sets each status bit whose data bit is 1 on the next clock edge. Data bits that are 0 leave their status bit unchanged. Bit positions: 0 accept, 1 success, 2 fail, 3 reject, 4 read overflow.
- R3: Reading offset 0x8 or 0x4 returns the status bits in positions 4:0, whatever the enable mask holds.
- R4: Writing 1 to bit 1 at offset 0x8 also sets command flag bit 0 (success). Writing 1 to bit 2 at offset 0x8 also sets command flag bit 1 (fail).
- R5: A one-cycle pulse on evt[i] sets status bit i on the next clock edge.
- R6: A write to offset 0x4 clears each status bit whose data bit is 1. It does not change the command flags.
- R7: When a clear and a set (from an event or from offset 0x8) hit the same status bit in the same cycle, the bit ends up set.
- R8: Offset 0x0 is the read-write enable mask in bits 4:0. irq_out goes high one clock after any status bit and its enable bit are both 1, and goes low one clock after no such pair remains.
- R9: Offset 0xC reads the command flags in bits 1:0. Events evt[1] and evt[2] set flag bits 0 and 1. Writing 1 to a flag bit clears it, and a set in the same cycle wins.
- R10: Bits 31:5 of every register read as 0, and writes to them are ignored. Unmapped offsets read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW (4) | Byte offset for both write and read |
| wdata | input | DW (32) | Write data |
| rdata | output | DW (32) | Combinational read data for addr |
| evt | input | 5 | One-cycle hardware event pulses, one per source |
| irq_out | output | 1 | Registered combined interrupt |

## Verification
The bench aims at same-cycle collisions. An event that lands with a clear of the same bit must leave the bit set; a design with the priority reversed would drop the interrupt. A clear write must leave the command flags unchanged; a design that shared the clear path would wipe out the success or fail record. Status reads taken with the enable mask at zero must still show the raw bits, which catches a design that masks the read data. The timing of irq_out is checked one clock after status and enable change, so an unregistered or twice-registered line gives the wrong value. Random writes to reserved bits and unmapped offsets show any register that decodes more bits than it should.

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [4:0]    evt,
  output logic          irq_out
);
  localparam int NS = 5;
  localparam logic [AW-1:0] OFS_EN  = AW'(0);
  localparam logic [AW-1:0] OFS_CLR = AW'(4);
  localparam logic [AW-1:0] OFS_SET = AW'(8);
  localparam logic [AW-1:0] OFS_CMD = AW'(12);

  logic [NS-1:0] sts_q, en_q;
  logic [1:0]    cmd_q;
  logic          irq_q;

  wire wr_en_r  = wr_en && (addr == OFS_EN);
  wire wr_clr_r = wr_en && (addr == OFS_CLR);
  wire wr_set_r = wr_en && (addr == OFS_SET);
  wire wr_cmd_r = wr_en && (addr == OFS_CMD);

  wire [NS-1:0] set_v = (wr_set_r ? wdata[NS-1:0] : '0) | evt;
  wire [NS-1:0] clr_v = wr_clr_r ? wdata[NS-1:0] : '0;
  wire [1:0]    cset  = {set_v[2], set_v[1]};
  wire [1:0]    cclr  = wr_cmd_r ? wdata[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
      cmd_q <= '0;
      irq_q <= 1'b0;
    end else begin
      sts_q <= (sts_q & ~clr_v) | set_v;
      cmd_q <= (cmd_q & ~cclr) | cset;
      if (wr_en_r) en_q <= wdata[NS-1:0];
      irq_q <= |(sts_q & en_q);
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      OFS_EN:           rdata[NS-1:0] = en_q;
      OFS_CLR, OFS_SET: rdata[NS-1:0] = sts_q;
      OFS_CMD:          rdata[1:0]    = cmd_q;
      default:          rdata = '0;
    endcase
  end

  assign irq_out = irq_q;
endmodule

module irq_status_bank_chk #(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic [4:0]    evt,
  input logic [4:0]    sts_q,
  input logic [4:0]    en_q,
  input logic [1:0]    cmd_q,
  input logic          irq_out
);
  p_set_w1s_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(8)) |=> ((sts_q & $past(wdata[4:0])) == $past(wdata[4:0])));

  p_evt_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((sts_q & $past(evt)) == $past(evt)));

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(4) && (|(evt & wdata[4:0]))) |=> ((sts_q & $past(evt)) == $past(evt)));

  p_clr_keeps_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(4) && !evt[1] && !evt[2]) |=> $stable(cmd_q));

  p_force_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(8) && wdata[1] && wdata[2]) |=> (cmd_q == 2'b11));

  p_irq_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sts_q & en_q)) |=> irq_out);

  p_irq_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(sts_q & en_q)) |=> !irq_out);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && evt == 5'd0) |=> $stable(sts_q));

  p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DW-1:5] == '0);
endmodule

bind irq_status_bank irq_status_bank_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .evt(evt), .sts_q(sts_q), .en_q(en_q), .cmd_q(cmd_q),
  .irq_out(irq_out)
);

// File: tb/irq_status_bank_tb.sv
`timescale 1ns/1ps
module irq_status_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [4:0]  evt = '0;
  logic        irq_out;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [4:0] m_sts = '0, m_en = '0;
  logic [1:0] m_cmd = '0;
  logic       m_irq = 1'b0;

  always #2 clk = ~clk;

  irq_status_bank dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt(evt), .irq_out(irq_out));

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    case (a)
      4'd0:       return {27'd0, m_en};
      4'd4, 4'd8: return {27'd0, m_sts};
      4'd12:      return {30'd0, m_cmd};
      default:    return 32'd0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit we, input logic [3:0] a, input logic [31:0] d, input logic [4:0] ev);
    logic [4:0] sv, cv;
    logic [1:0] cc;
    @(negedge clk);
    wr_en = we; addr = a; wdata = d; evt = ev;
    @(posedge clk);
    sv = ((we && a == 4'd8) ? d[4:0] : 5'd0) | ev;
    cv = (we && a == 4'd4) ? d[4:0] : 5'd0;
    cc = (we && a == 4'd12) ? d[1:0] : 2'b00;
    m_irq = |(m_sts & m_en);
    m_sts = (m_sts & ~cv) | sv;
    m_cmd = (m_cmd & ~cc) | {sv[2], sv[1]};
    if (we && a == 4'd0) m_en = d[4:0];
    #1;
    chk(irq_out === m_irq, "R8 irq_out", {31'd0, irq_out}, {31'd0, m_irq});
  endtask

  task automatic rd(input logic [3:0] a, input string req);
    @(negedge clk);
    wr_en = 1'b0; evt = '0; addr = a;
    #1;
    chk(rdata === exp_read(a), req, rdata, exp_read(a));
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(posedge clk);
    #1;
    chk(irq_out === 1'b0, "R1 irq reset", {31'd0, irq_out}, 32'd0);
    rst_n = 1'b1;
    rd(4'd0, "R1 enable reset"); rd(4'd8, "R1 status reset"); rd(4'd12, "R1 cmd reset");

    step(1, 4'd8, 32'h0000_0000, 5'd0); rd(4'd8, "R2 write zero no effect");
    step(1, 4'd8, 32'h0000_0009, 5'd0); rd(4'd8, "R2 set accept+reject");
    rd(4'd12, "R4 no flag from bits 0,3");
    rd(4'd4, "R3 raw status with enable 0");
    step(1, 4'd8, 32'h0000_0002, 5'd0); rd(4'd12, "R4 success flag");
    step(1, 4'd8, 32'h0000_0004, 5'd0); rd(4'd12, "R4 fail flag");
    step(1, 4'd4, 32'h0000_001F, 5'd0); rd(4'd8, "R6 clear all");
    rd(4'd12, "R6 flags kept after clear");
    step(0, 4'd0, 32'h0, 5'b10000); rd(4'd8, "R5 overflow event");
    step(1, 4'd4, 32'h0000_0010, 5'b10000); rd(4'd8, "R7 set wins over clear");
    step(1, 4'd12, 32'h0000_0003, 5'b00010); rd(4'd12, "R9 event wins over flag clear");
    step(1, 4'd12, 32'h0000_0001, 5'd0); rd(4'd12, "R9 flag clear");
    step(1, 4'd0, 32'hFFFF_FFF0, 5'd0); rd(4'd0, "R10 enable reserved bits");
    step(0, 4'd0, 32'h0, 5'd0); step(0, 4'd0, 32'h0, 5'd0);
    chk(irq_out === 1'b1, "R8 irq with overflow enabled", {31'd0, irq_out}, 32'd1);
    step(1, 4'd2, 32'hFFFF_FFFF, 5'd0); rd(4'd2, "R10 unmapped read");
    rd(4'd0, "R10 unmapped write ignored"); rd(4'd8, "R10 status after unmapped write");
    step(1, 4'd0, 32'h0, 5'd0); step(0, 4'd0, 32'h0, 5'd0); step(0, 4'd0, 32'h0, 5'd0);
    chk(irq_out === 1'b0, "R8 irq drops with enable 0", {31'd0, irq_out}, 32'd0);
    rd(4'd8, "R3 status kept with enable 0");

    for (int i = 0; i < 600; i++) begin
      logic [3:0] a;
      logic [4:0] ev;
      int s = $urandom_range(0, 9);
      a = (s < 8) ? 4'(4 * (s % 4)) : 4'($urandom_range(0, 15));
      ev = ($urandom_range(0, 3) == 0) ? 5'($urandom) : 5'd0;
      step($urandom_range(0, 2) != 0, a, $urandom, ev);
      if (i % 3 == 0) begin
        rd(4'd0, "R8 random enable"); rd(4'd8, "R2 random status");
        rd(4'd4, "R6 random status"); rd(4'd12, "R9 random flags");
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule